// File: doc/BRIEF.md
# Timer-Overflow Baud Rate Generator

This block produces the bit timing for an asynchronous serial port from an 8-bit auto-reload counter. The counter advances on a count enable taken from one of three places: every system clock, one system clock in twelve, or the rising edges of an external clock pin after they have been synchronised. When the counter passes its top value it reloads from a reload register and emits a one-cycle overflow pulse. The overflow rate is therefore the count rate divided by (256 - reload).

The overflow stream becomes a 16x oversampling tick. With the double-speed input low, every second overflow counts. With it high, every overflow counts. A divide-by-16 stage turns that tick into a one-cycle bit-rate enable. The transmit and receive paths each have their own tick and bit enable, and each chooses its own source: this timer, or the overflow pulses of an external 16-bit timer. On that external path every incoming pulse is a 16x tick and the double-speed input has no effect. The final bit rate is the count rate / (256 - reload) / 32, or / 16 with double speed set.

The double-speed control is a plain level input here. The register that drives it is expected to reset to 0, which gives the slower rate by default.

Top module: `ovf_baud_gen`

## Requirements
- R1: During and right after reset, the counter and reload register hold 0 and every output (`tmr_ovf`, both 16x ticks, both bit enables) is 0.
- R2: The counter is 8 bits wide. On a count enable at value 0xFF it loads the reload register instead of incrementing, and `tmr_ovf` is high for exactly the one cycle after that edge. Overflows occur once every (256 - reload) count enables.
- R3: With `clk_sel` = 2'b01 the counter advances on every clock cycle, so the overflow period is (256 - reload) cycles.
- R4: With `clk_sel` = 2'b00 the counter advances once every 12 clock cycles, so the overflow period is 12 x (256 - reload) cycles.
- R5: With `clk_sel` = 2'b10 or 2'b11 the counter advances once per rising edge of `ext_clk`. That input passes through a two-flop synchroniser before edge detection.
- R6: A `reload_wr` pulse stores `reload_val` in the reload register without touching the running count. The new value first applies at the following overflow, so the interval already in progress keeps its old length.
- R7: A source select of 0 picks this timer. With `dbl_speed` = 0 the 16x tick fires on every second timer overflow. With `dbl_speed` = 1 it fires on every overflow. The tick lags its overflow by one cycle.
- R8: Each bit enable is high for one cycle on every 16th 16x tick of its own path, always in the same cycle as that tick.
- R9: A source select of 1 makes that path's 16x tick follow `alt_ovf` one cycle later, pulse for pulse, whatever the value of `dbl_speed`.
- R10: `tx_src_sel` and `rx_src_sel` act independently. The transmit and receive paths have separate tick and bit-enable dividers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Count source: 00 = clock/12, 01 = every clock, 1x = external pin edges |
| ext_clk | input | 1 | Asynchronous external count clock |
| reload_val | input | 8 | Reload value to store |
| reload_wr | input | 1 | One-cycle strobe that stores `reload_val` |
| dbl_speed | input | 1 | 1 = use every timer overflow, 0 = use every second one |
| tx_src_sel | input | 1 | Transmit source: 0 = this timer, 1 = `alt_ovf` |
| rx_src_sel | input | 1 | Receive source: 0 = this timer, 1 = `alt_ovf` |
| alt_ovf | input | 1 | One-cycle overflow pulses from an external 16-bit timer |
| tmr_ovf | output | 1 | One-cycle overflow pulse of the 8-bit timer |
| tx_tick16 | output | 1 | Transmit 16x oversampling tick |
| tx_bit_en | output | 1 | Transmit bit-rate enable |
| rx_tick16 | output | 1 | Receive 16x oversampling tick |
| rx_bit_en | output | 1 | Receive bit-rate enable |

## Verification
The assertions assume that `alt_ovf` is a clean, synchronous signal that changes only between clock edges. They also assume `clk_sel` holds for at least one cycle around each count step they check, since the full-rate step property compares against the previous cycle's source. The bench drives every input a fixed delay after the rising edge, and it generates the external pin and `alt_ovf` patterns from their own processes at that same offset. Changes to the count source happen only between measurement windows, and each period measurement throws away the first interval after a change.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int CNT_W   = 8;
    localparam int PRE_DIV = 12;
    localparam int OVS     = 16;
    localparam int PRE_W   = $clog2(PRE_DIV);
    localparam int OVS_W   = $clog2(OVS);
    localparam int N_DIR   = 2;
    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;

    typedef enum logic [1:0] {
        CS_DIV12 = 2'b00,
        CS_FULL  = 2'b01,
        CS_EXT   = 2'b10,
        CS_EXT2  = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic tick16;
        logic bit_en;
    } rate_out_t;

    function automatic logic at_top(input logic [CNT_W-1:0] v);
        return &v;
    endfunction

endpackage

// File: rtl/count_enable.sv
module count_enable
    import baud_pkg::*;
#(
    parameter int DIV = PRE_DIV
) (
    input  logic       clk,
    input  logic       rst,
    input  clk_sel_e   sel,
    input  logic       ext_in,
    output logic       cnt_en
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] pre_q;
    logic          pre_hit;
    logic [2:0]    sync_q;
    logic          ext_rise;

    assign pre_hit = (pre_q == DW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (pre_hit) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ext_in};
        end
    end

    assign ext_rise = sync_q[1] & ~sync_q[2];

    always_comb begin
        unique case (sel)
            CS_FULL:  cnt_en = 1'b1;
            CS_DIV12: cnt_en = pre_hit;
            default:  cnt_en = ext_rise;
        endcase
    end

endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             reload_wr,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             ovf_q
);
    logic wrap;

    assign wrap = cnt_en & at_top(cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= reload_q;
        end else if (cnt_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (reload_wr) begin
            reload_q <= reload_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap;
        end
    end

endmodule

// File: rtl/rate_divider.sv
module rate_divider
    import baud_pkg::*;
#(
    parameter int RATIO = OVS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_in,
    output rate_out_t out_q
);
    localparam int RW = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [RW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == RW'(RATIO - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.tick16 <= tick_in;
            out_q.bit_en <= tick_in & last;
        end
    end

endmodule

// File: rtl/ovf_baud_gen.sv
module ovf_baud_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       clk_sel,
    input  logic             ext_clk,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             reload_wr,
    input  logic             dbl_speed,
    input  logic             tx_src_sel,
    input  logic             rx_src_sel,
    input  logic             alt_ovf,
    output logic             tmr_ovf,
    output logic             tx_tick16,
    output logic             tx_bit_en,
    output logic             rx_tick16,
    output logic             rx_bit_en
);
    logic             cnt_en;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             ovf_q;
    logic             half_q;
    logic             timer_tick;
    logic [N_DIR-1:0] src_sel;
    rate_out_t        path_out [N_DIR];

    count_enable #(.DIV(PRE_DIV)) u_cen (
        .clk    (clk),
        .rst    (rst),
        .sel    (clk_sel_e'(clk_sel)),
        .ext_in (ext_clk),
        .cnt_en (cnt_en)
    );

    reload_timer u_tmr (
        .clk        (clk),
        .rst        (rst),
        .cnt_en     (cnt_en),
        .reload_val (reload_val),
        .reload_wr  (reload_wr),
        .cnt_q      (cnt_q),
        .reload_q   (reload_q),
        .ovf_q      (ovf_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
        end else if (ovf_q) begin
            half_q <= ~half_q;
        end
    end

    assign timer_tick = ovf_q & (dbl_speed | half_q);

    assign src_sel[DIR_TX] = tx_src_sel;
    assign src_sel[DIR_RX] = rx_src_sel;

    for (genvar d = 0; d < N_DIR; d++) begin : g_path
        logic tick_src;
        assign tick_src = src_sel[d] ? alt_ovf : timer_tick;
        rate_divider #(.RATIO(OVS)) u_div (
            .clk     (clk),
            .rst     (rst),
            .tick_in (tick_src),
            .out_q   (path_out[d])
        );
    end

    assign tmr_ovf   = ovf_q;
    assign tx_tick16 = path_out[DIR_TX].tick16;
    assign tx_bit_en = path_out[DIR_TX].bit_en;
    assign rx_tick16 = path_out[DIR_RX].tick16;
    assign rx_bit_en = path_out[DIR_RX].bit_en;

endmodule

// File: rtl/ovf_baud_gen_chk.sv
module ovf_baud_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] clk_sel,
    input logic [7:0] cnt_q,
    input logic [7:0] reload_q,
    input logic       tmr_ovf,
    input logic       tx_src_sel,
    input logic       rx_src_sel,
    input logic       alt_ovf,
    input logic       tx_tick16,
    input logic       tx_bit_en,
    input logic       rx_tick16,
    input logic       rx_bit_en
);
    // R2: after an overflow the counter holds the reload value from before that edge
    a_r2_reload_on_wrap: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |-> cnt_q == $past(reload_q));

    // R3: at full rate, a cycle without overflow is a single increment
    a_r3_full_step: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(clk_sel) == 2'b01 && !tmr_ovf)
            |-> cnt_q == 8'($past(cnt_q) + 8'd1));

    // R8: bit enable only together with the 16x tick
    a_r8_tx_bit_in_tick: assert property (@(posedge clk) disable iff (rst)
        tx_bit_en |-> tx_tick16);
    a_r8_rx_bit_in_tick: assert property (@(posedge clk) disable iff (rst)
        rx_bit_en |-> rx_tick16);

    // R9: external-overflow source passes straight through one cycle later
    a_r9_tx_alt_follow: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(tx_src_sel)) |-> tx_tick16 == $past(alt_ovf));

    // R10: the receive select works on its own path
    a_r10_rx_alt_follow: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(rx_src_sel)) |-> rx_tick16 == $past(alt_ovf));

endmodule

bind ovf_baud_gen ovf_baud_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_sel    (clk_sel),
    .cnt_q      (cnt_q),
    .reload_q   (reload_q),
    .tmr_ovf    (tmr_ovf),
    .tx_src_sel (tx_src_sel),
    .rx_src_sel (rx_src_sel),
    .alt_ovf    (alt_ovf),
    .tx_tick16  (tx_tick16),
    .tx_bit_en  (tx_bit_en),
    .rx_tick16  (rx_tick16),
    .rx_bit_en  (rx_bit_en)
);

// File: tb/sim_ovf_baud_gen.sv
`timescale 1ns/1ps
module sim_ovf_baud_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] clk_sel = 2'b01;
    logic       ext_clk = 1'b0;
    logic [7:0] reload_val = 8'h00;
    logic       reload_wr = 1'b0;
    logic       dbl_speed = 1'b0;
    logic       tx_src_sel = 1'b0;
    logic       rx_src_sel = 1'b0;
    logic       alt_ovf = 1'b0;
    logic       tmr_ovf, tx_tick16, tx_bit_en, rx_tick16, rx_bit_en;

    int n_chk = 0;
    int n_fail = 0;
    int ncyc = 0;
    bit done = 0;
    int ext_half = 0;   // 0 = external pin idle, else half period in cycles
    int alt_per = 0;    // 0 = no alt pulses, else period in cycles

    always #10 clk = ~clk;

    ovf_baud_gen u0 (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .ext_clk(ext_clk),
        .reload_val(reload_val), .reload_wr(reload_wr), .dbl_speed(dbl_speed),
        .tx_src_sel(tx_src_sel), .rx_src_sel(rx_src_sel), .alt_ovf(alt_ovf),
        .tmr_ovf(tmr_ovf), .tx_tick16(tx_tick16), .tx_bit_en(tx_bit_en),
        .rx_tick16(rx_tick16), .rx_bit_en(rx_bit_en)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, ncyc);
        end
    endtask

    // pattern generators, driven after the edge
    int ext_cnt = 0;
    int alt_cnt = 0;
    always begin
        @(posedge clk); #3;
        if (ext_half > 0) begin
            ext_cnt++;
            if (ext_cnt >= ext_half) begin ext_cnt = 0; ext_clk = ~ext_clk; end
        end
        if (alt_per > 0) begin
            alt_cnt++;
            if (alt_cnt >= alt_per) begin alt_cnt = 0; alt_ovf = 1'b1; end
            else alt_ovf = 1'b0;
        end else alt_ovf = 1'b0;
    end

    // behavioural reference model
    int m_pre, m_cnt, m_rel, m_e1, m_e2, m_e3, m_tog;
    int m_ovf, m_t16 [2], m_ben [2], m_dv [2];
    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_rel = 0; m_e1 = 0; m_e2 = 0; m_e3 = 0; m_tog = 0;
            m_ovf = 0;
            for (int d = 0; d < 2; d++) begin m_t16[d] = 0; m_ben[d] = 0; m_dv[d] = 0; end
        end else begin
            int en, ttick, nx;
            int pt [2];
            if (clk_sel == 2'b01) en = 1;
            else if (clk_sel == 2'b00) en = (m_pre == 11);
            else en = (m_e2 == 1 && m_e3 == 0);
            ttick = (m_ovf != 0 && (dbl_speed || m_tog != 0)) ? 1 : 0;
            pt[0] = tx_src_sel ? int'(alt_ovf) : ttick;
            pt[1] = rx_src_sel ? int'(alt_ovf) : ttick;
            nx = (en != 0 && m_cnt == 255) ? 1 : 0;
            if (en != 0) m_cnt = (m_cnt == 255) ? m_rel : m_cnt + 1;
            if (reload_wr) m_rel = int'(reload_val);
            m_pre = (m_pre + 1) % 12;
            m_e3 = m_e2; m_e2 = m_e1; m_e1 = int'(ext_clk);
            if (m_ovf != 0) m_tog = 1 - m_tog;
            for (int d = 0; d < 2; d++) begin
                m_t16[d] = pt[d];
                m_ben[d] = (pt[d] != 0 && m_dv[d] == 15) ? 1 : 0;
                if (pt[d] != 0) m_dv[d] = (m_dv[d] + 1) % 16;
            end
            m_ovf = nx;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        ncyc++;
        if (!done) begin
            chk("R2", int'(tmr_ovf), m_ovf, "tmr_ovf vs model");
            chk("R7", int'(tx_tick16), m_t16[0], "tx_tick16 vs model");
            chk("R8", int'(tx_bit_en), m_ben[0], "tx_bit_en vs model");
            chk("R10", int'(rx_tick16), m_t16[1], "rx_tick16 vs model");
            chk("R8", int'(rx_bit_en), m_ben[1], "rx_bit_en vs model");
        end
    end

    function automatic logic sig(input int w);
        case (w)
            0: return tmr_ovf;
            1: return tx_tick16;
            2: return tx_bit_en;
            3: return rx_tick16;
            default: return rx_bit_en;
        endcase
    endfunction

    // interval between the 2nd and 3rd pulses seen on output w
    task automatic period_of(input int w, output int p);
        int seen = 0, t2 = 0, guard = 0;
        p = -1;
        while (seen < 3 && guard < 20000) begin
            @(negedge clk); #1;
            guard++;
            if (sig(w)) begin
                seen++;
                if (seen == 2) t2 = ncyc;
                if (seen == 3) p = ncyc - t2;
            end
        end
    endtask

    task automatic wr_reload(input int v);
        @(posedge clk); #2;
        reload_val = 8'(v); reload_wr = 1'b1;
        @(posedge clk); #2;
        reload_wr = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // watchdog
    always @(posedge clk) begin
        if (ncyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", ncyc);
            summary();
            $finish;
        end
    end

    initial begin
        int p, t0, t1, t2;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: reset state
        chk("R1", int'(tmr_ovf), 0, "tmr_ovf in reset");
        chk("R1", int'(tx_tick16 | rx_tick16), 0, "ticks in reset");
        chk("R1", int'(tx_bit_en | rx_bit_en), 0, "bit enables in reset");
        @(posedge clk); #2; rst = 1'b0;
        @(negedge clk); #1;
        chk("R1", int'(tmr_ovf | tx_tick16 | rx_tick16 | tx_bit_en | rx_bit_en), 0, "outputs after reset");

        // R2/R3: full rate, reload 0xF6 -> 10 cycles
        wr_reload(8'hF6);
        period_of(0, p); chk("R3", p, 10, "overflow period full rate F6");
        period_of(1, p); chk("R7", p, 20, "tx tick period dbl=0");
        period_of(2, p); chk("R8", p, 320, "tx bit period dbl=0");
        @(posedge clk); #2; dbl_speed = 1'b1;
        period_of(1, p); chk("R7", p, 10, "tx tick period dbl=1");
        period_of(4, p); chk("R8", p, 160, "rx bit period dbl=1");

        // R2: reload 0xFF overflows on every count enable
        wr_reload(8'hFF);
        period_of(0, p); chk("R2", p, 1, "overflow period reload FF");

        // R4: clock/12 with reload 0xFE -> 24 cycles
        @(posedge clk); #2; clk_sel = 2'b00;
        wr_reload(8'hFE);
        period_of(0, p); chk("R4", p, 24, "overflow period div12 FE");

        // R5: external pin, period 6 cycles, reload 0xFC -> 24 cycles
        ext_half = 3;
        @(posedge clk); #2; clk_sel = 2'b10;
        wr_reload(8'hFC);
        period_of(0, p); chk("R5", p, 24, "overflow period ext sel 10");
        @(posedge clk); #2; clk_sel = 2'b11;
        period_of(0, p); chk("R5", p, 24, "overflow period ext sel 11");
        ext_half = 0;

        // R6: reload write mid-interval applies at the next overflow
        @(posedge clk); #2; clk_sel = 2'b01;
        wr_reload(8'hF6);
        period_of(0, p);
        while (1) begin @(negedge clk); #1; if (tmr_ovf) break; end
        t0 = ncyc;
        wr_reload(8'hF0);
        while (1) begin @(negedge clk); #1; if (tmr_ovf) break; end
        t1 = ncyc;
        while (1) begin @(negedge clk); #1; if (tmr_ovf) break; end
        t2 = ncyc;
        chk("R6", t1 - t0, 10, "interval in progress at write");
        chk("R6", t2 - t1, 16, "first interval with new reload");

        // R9/R10: tx on alt pulses every 5 cycles, rx stays on timer
        wr_reload(8'hF6);
        @(posedge clk); #2; dbl_speed = 1'b0; alt_per = 5;
        @(posedge clk); #2; tx_src_sel = 1'b1;
        period_of(1, p); chk("R9", p, 5, "tx tick on alt dbl=0");
        period_of(2, p); chk("R9", p, 80, "tx bit on alt dbl=0");
        period_of(3, p); chk("R10", p, 20, "rx tick stays on timer");
        @(posedge clk); #2; dbl_speed = 1'b1;
        period_of(1, p); chk("R9", p, 5, "tx tick on alt dbl=1");
        @(posedge clk); #2; tx_src_sel = 1'b0; rx_src_sel = 1'b1;
        period_of(3, p); chk("R10", p, 5, "rx tick on alt");
        period_of(1, p); chk("R10", p, 10, "tx tick back on timer");

        repeat (20) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule